// File: doc/BRIEF.md
# Machine-Cycle T-State Sequencer

This block steps a processor core through the T states of each machine cycle. One clock stands for one T state. A cycle runs T1, T2 and T3, and then either ends or, in an opcode-fetch (M1) cycle, carries on to T4. A long M1 also runs T5 and T6. The current state is shown on a one-hot vector. Several conditions stretch or suspend this sequence:

- **Wait states.** These are inserted after T2 while READY is low. They are not inserted in bus-idle cycles or in the internally generated restart/trap fetch.
- **Bus hold.** A hold request is granted only at T3 or T5. The rest of an M1 is allowed to finish first. No new T1 starts until the request is released.
- **Halt.** A halt instruction stops the sequence after its T1. An interrupt then restarts it at a fresh T1.

The surrounding control logic tells the block whether the current cycle is an M1 and whether that M1 is long. The block does not need a cycle-end strobe from outside, because it knows where a cycle ends: at T3 in ordinary cycles, at T4 in a short M1 and at T6 in a long one. The bus-enable output drives the tri-state control of the address and control pins.

Top module: `tstate_gen`

## Requirements
- R1: While `rst` is high, all T outputs and `wait_st` are 0, `hlda` is 0, `halt_st` is 1 and `bus_en` is 0. The first state after `rst` falls is T1.
- R2: `t_state` is one-hot or zero: bit 0 is T1, bit 1 is T2 and so on up to bit 5 for T6. T1 is always followed by T2 unless halt entry (R9) applies.
- R3: In T2, a low `ready` makes the next state a wait state (`wait_st`=1, `t_state`=0). A wait state repeats while `ready` is low and is followed by T3 once it is high.
- R4: When `idle_cyc` or `int_internal` is high, T2 is always followed by T3 whatever the level of `ready`.
- R5: T3 is followed by T4 only when `is_m1` is high. T4 is followed by T5 only when `long_m1` is high. T5 is always followed by T6. The cycle ends after T3 in a non-M1 cycle, after T4 in a short M1 and after T6 in a long M1, and the next state is T1 unless a hold is granted.
- R6: `hold_req` is sampled only in T3 and T5 (and while halted, R11). If it is high there, `hlda` is 1 from the next state on.
- R7: Once `hlda` is set, the remaining states of the current cycle still run. At the cycle end the hold state follows instead of T1, with `t_state`=0.
- R8: In the hold state, a low `hold_req` clears `hlda` and makes T1 the next state.
- R9: In T1, a high `halt_instr` with `int_pending` low makes the next state halt (`halt_st`=1, `t_state`=0) with no T2. With `int_pending` high, T2 follows as usual.
- R10: While halted with `hold_req` low, a high `int_pending` clears `halt_st` and makes T1 the next state.
- R11: While halted, `hlda` takes the value `hold_req` had in the previous state. The halt is not left while `hold_req` is high, even if an interrupt is pending.
- R12: `bus_en` is 0 exactly when `halt_st` or `hlda` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one period per T state |
| rst | input | 1 | Synchronous active-high reset |
| is_m1 | input | 1 | Current machine cycle is an opcode fetch |
| long_m1 | input | 1 | Current M1 runs six states |
| ready | input | 1 | Memory/IO ready, low requests wait states |
| idle_cyc | input | 1 | Current cycle does no bus transfer |
| int_internal | input | 1 | Current M1 is an internally supplied restart/trap fetch |
| hold_req | input | 1 | External bus hold request |
| halt_instr | input | 1 | Decoded instruction is a halt |
| int_pending | input | 1 | An interrupt is being taken |
| t_state | output | 6 | One-hot T1..T6 indication |
| wait_st | output | 1 | Wait state in progress |
| halt_st | output | 1 | Halted (also high during reset) |
| hlda | output | 1 | Hold acknowledge |
| bus_en | output | 1 | High when the buses may be driven |

## Verification
The bench raises a hold request early in a long M1 and checks that T4 to T6 still run before the hold state. A design that granted the hold at once would cut off the fetch. It keeps READY low through bus-idle cycles and internal restart fetches, where a design that forgot the exemption would insert waits. While halted, it asserts hold and then an interrupt together, so a design that took the interrupt during the hold would restart T1 with the buses released. It also sends a halt instruction alongside a pending interrupt, which must not halt. Finally, it asserts reset in the middle of a cycle to show that the sequence stops and restarts at T1.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  localparam int T_COUNT = 6;
  localparam int ST_W    = 4;

  typedef enum logic [ST_W-1:0] {
    ST_T1   = 4'd0,
    ST_T2   = 4'd1,
    ST_T3   = 4'd2,
    ST_T4   = 4'd3,
    ST_T5   = 4'd4,
    ST_T6   = 4'd5,
    ST_WAIT = 4'd6,
    ST_HOLD = 4'd7,
    ST_HALT = 4'd8,
    ST_STOP = 4'd9
  } tstate_e;
endpackage

// File: rtl/tsg_wait_gate.sv
module tsg_wait_gate (
  input  logic ready,
  input  logic idle_cyc,
  input  logic int_internal,
  output logic need_wait
);
  logic exempt;

  always_comb begin
    exempt    = idle_cyc | int_internal;
    need_wait = ~ready & ~exempt;
  end
endmodule

// File: rtl/tsg_hold_ctrl.sv
module tsg_hold_ctrl
  import tsg_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  tstate_e state,
  input  logic    hold_req,
  output logic    hold_take,
  output logic    hlda
);
  logic safe_point;

  always_comb begin
    safe_point = (state == ST_T3) || (state == ST_T5);
    hold_take  = safe_point && hold_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hlda <= 1'b0;
    end else begin
      if (hold_take) begin
        hlda <= 1'b1;
      end else if (state == ST_HOLD && !hold_req) begin
        hlda <= 1'b0;
      end else if (state == ST_HALT) begin
        hlda <= hold_req;
      end
    end
  end

  // R6: acknowledge only rises after a safe point or while halted
  a_r6_hlda_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(hlda) |-> $past(state == ST_T3 || state == ST_T5 || state == ST_HALT));

  // R8: acknowledge only falls out of the hold or halt state
  a_r8_hlda_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(hlda) |-> $past(state == ST_HOLD || state == ST_HALT));
endmodule

// File: rtl/tsg_seq.sv
module tsg_seq
  import tsg_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    is_m1,
  input  logic    long_m1,
  input  logic    need_wait,
  input  logic    hold_req,
  input  logic    hold_take,
  input  logic    hlda,
  input  logic    halt_instr,
  input  logic    int_pending,
  output tstate_e state
);
  tstate_e next_st;
  tstate_e end_st;
  logic    grant;

  always_comb begin
    grant  = hlda | hold_take;
    end_st = grant ? ST_HOLD : ST_T1;
    case (state)
      ST_T1:   next_st = (halt_instr && !int_pending) ? ST_HALT : ST_T2;
      ST_T2:   next_st = need_wait ? ST_WAIT : ST_T3;
      ST_WAIT: next_st = need_wait ? ST_WAIT : ST_T3;
      ST_T3:   next_st = is_m1 ? ST_T4 : end_st;
      ST_T4:   next_st = long_m1 ? ST_T5 : end_st;
      ST_T5:   next_st = ST_T6;
      ST_T6:   next_st = end_st;
      ST_HOLD: next_st = hold_req ? ST_HOLD : ST_T1;
      ST_HALT: next_st = (!hold_req && int_pending) ? ST_T1 : ST_HALT;
      ST_STOP: next_st = ST_T1;
      default: next_st = ST_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_STOP;
    else     state <= next_st;
  end

  // R3: a wait state is only reached from T2 or another wait state
  a_r3_wait_source: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> $past(state == ST_T2 || state == ST_WAIT));

  // R5: T4 only after T3 of an M1 cycle
  a_r5_t4_in_m1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_T4) |-> $past(state == ST_T3 && is_m1));

  // R9: halt instruction at T1 without interrupt stops the sequence
  a_r9_halt_entry: assert property (@(posedge clk) disable iff (rst)
    (state == ST_T1 && halt_instr && !int_pending) |=> (state == ST_HALT));

  // R10: interrupt without hold leaves the halt through T1
  a_r10_halt_exit: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HALT && int_pending && !hold_req) |=> (state == ST_T1));
endmodule

// File: rtl/tstate_gen.sv
module tstate_gen
  import tsg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               is_m1,
  input  logic               long_m1,
  input  logic               ready,
  input  logic               idle_cyc,
  input  logic               int_internal,
  input  logic               hold_req,
  input  logic               halt_instr,
  input  logic               int_pending,
  output logic [T_COUNT-1:0] t_state,
  output logic               wait_st,
  output logic               halt_st,
  output logic               hlda,
  output logic               bus_en
);
  tstate_e state;
  logic    need_wait;
  logic    hold_take;

  tsg_wait_gate u_wait (
    .ready        (ready),
    .idle_cyc     (idle_cyc),
    .int_internal (int_internal),
    .need_wait    (need_wait)
  );

  tsg_hold_ctrl u_hold (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .hold_req  (hold_req),
    .hold_take (hold_take),
    .hlda      (hlda)
  );

  tsg_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .is_m1       (is_m1),
    .long_m1     (long_m1),
    .need_wait   (need_wait),
    .hold_req    (hold_req),
    .hold_take   (hold_take),
    .hlda        (hlda),
    .halt_instr  (halt_instr),
    .int_pending (int_pending),
    .state       (state)
  );

  for (genvar i = 0; i < T_COUNT; i++) begin : g_tdec
    assign t_state[i] = (state == tstate_e'(ST_W'(i)));
  end

  assign wait_st = (state == ST_WAIT);
  assign halt_st = (state == ST_HALT) || (state == ST_STOP);
  assign bus_en  = ~(halt_st | hlda);

  // R2: never more than one T state at a time
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({t_state, wait_st}));

  // R4: exempt cycles never wait
  a_r4_no_wait_exempt: assert property (@(posedge clk) disable iff (rst)
    (t_state[1] && (idle_cyc || int_internal)) |=> !wait_st);

  // R7: during hold acknowledge no new T1 is started from a cycle end
  a_r7_no_t1_in_hold: assert property (@(posedge clk) disable iff (rst)
    (hlda && $past(hlda) && !$past(halt_st)) |-> !t_state[0]);
endmodule

// File: tb/tb_tstate_gen.sv
module tb_tstate_gen;
  logic clk = 1'b0;
  logic rst, is_m1, long_m1, ready, idle_cyc, int_internal;
  logic hold_req, halt_instr, int_pending;
  logic [5:0] t_state;
  logic wait_st, halt_st, hlda, bus_en;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  int ms = 9;     // 0..5 T1..T6, 6 wait, 7 hold, 8 halt, 9 reset stop
  bit mh = 1'b0;
  int waits_seen = 0;

  always #2.5 clk = ~clk;

  tstate_gen dut (
    .clk(clk), .rst(rst), .is_m1(is_m1), .long_m1(long_m1), .ready(ready),
    .idle_cyc(idle_cyc), .int_internal(int_internal), .hold_req(hold_req),
    .halt_instr(halt_instr), .int_pending(int_pending), .t_state(t_state),
    .wait_st(wait_st), .halt_st(halt_st), .hlda(hlda), .bus_en(bus_en)
  );

  // behavioural reference of the state sequence
  always @(posedge clk) begin
    int nx;
    bit nh;
    bit take, grant, needw;
    nx = ms;
    nh = mh;
    if (rst) begin
      nx = 9;
      nh = 1'b0;
    end else begin
      take  = (ms == 2 || ms == 4) && hold_req;
      grant = mh || take;
      needw = !ready && !idle_cyc && !int_internal;
      if (take) nh = 1'b1;
      if (ms == 7 && !hold_req) nh = 1'b0;
      if (ms == 8) nh = hold_req;
      case (ms)
        0: nx = (halt_instr && !int_pending) ? 8 : 1;
        1, 6: nx = needw ? 6 : 2;
        2: nx = is_m1 ? 3 : (grant ? 7 : 0);
        3: nx = long_m1 ? 4 : (grant ? 7 : 0);
        4: nx = 5;
        5: nx = grant ? 7 : 0;
        7: nx = hold_req ? 7 : 0;
        8: nx = (int_pending && !hold_req) ? 0 : 8;
        default: nx = 0;
      endcase
    end
    ms = nx;
    mh = nh;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [5:0] et;
    bit eh;
    et = (ms < 6) ? 6'(1 << ms) : 6'd0;
    eh = (ms == 8 || ms == 9);
    if (wait_st) waits_seen++;
    check(t_state == et, cur_req, "t_state", int'(t_state), int'(et));
    check(wait_st == (ms == 6), cur_req, "wait_st", int'(wait_st), int'(ms == 6));
    check(halt_st == eh, cur_req, "halt_st", int'(halt_st), int'(eh));
    check(hlda == mh, cur_req, "hlda", int'(hlda), int'(mh));
    check(bus_en == !(eh || mh), "R12", "bus_en", int'(bus_en), int'(!(eh || mh)));
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_for(input int s);
    for (int g = 0; g < 40 && ms != s; g++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; is_m1 = 1'b1; long_m1 = 1'b0; ready = 1'b1; idle_cyc = 1'b0;
    int_internal = 1'b0; hold_req = 1'b0; halt_instr = 1'b0; int_pending = 1'b0;
    cyc(3);
    // R1 reset values at the ports
    check(t_state == 6'd0 && halt_st && !bus_en && !hlda, "R1", "reset outputs",
          int'({t_state, halt_st, bus_en, hlda}), int'(9'b000000100));
    rst = 1'b0;
    cur_req = "R2"; cyc(8);
    wait_for(0); is_m1 = 1'b0; cur_req = "R5"; cyc(8);
    wait_for(0); is_m1 = 1'b1; long_m1 = 1'b1; cyc(14);
    // R3 wait insertion
    wait_for(0); is_m1 = 1'b0; long_m1 = 1'b0; ready = 1'b0; cur_req = "R3";
    waits_seen = 0; cyc(5); ready = 1'b1; cyc(6);
    check(waits_seen > 0, "R3", "wait states seen", waits_seen, 1);
    // R4 exempt cycles
    wait_for(0); idle_cyc = 1'b1; ready = 1'b0; cur_req = "R4"; waits_seen = 0; cyc(8);
    idle_cyc = 1'b0; int_internal = 1'b1;
    wait_for(0); is_m1 = 1'b1; cyc(8);
    check(waits_seen == 0, "R4", "wait states seen", waits_seen, 0);
    int_internal = 1'b0; ready = 1'b1;
    // R6 R7 hold during long M1
    wait_for(0); long_m1 = 1'b1; hold_req = 1'b1; cur_req = "R6"; cyc(3);
    cur_req = "R7"; cyc(7);
    check(hlda && t_state == 6'd0, "R7", "hold state", int'({hlda, t_state}), 64);
    hold_req = 1'b0; cur_req = "R8"; cyc(4);
    wait_for(0); is_m1 = 1'b0; long_m1 = 1'b0; hold_req = 1'b1; cur_req = "R6"; cyc(5);
    hold_req = 1'b0; cur_req = "R8"; cyc(3);
    // R9 halt entry
    wait_for(0); is_m1 = 1'b1; halt_instr = 1'b1; cur_req = "R9"; cyc(3);
    halt_instr = 1'b0;
    check(halt_st && t_state == 6'd0, "R9", "halted", int'({halt_st, t_state}), 64);
    // R11 hold while halted blocks interrupt
    hold_req = 1'b1; cur_req = "R11"; cyc(3);
    int_pending = 1'b1; cyc(2);
    check(halt_st && hlda, "R11", "halt and hold", int'({halt_st, hlda}), 3);
    hold_req = 1'b0; cur_req = "R10"; cyc(4);
    check(!halt_st, "R10", "halt left", int'(halt_st), 0);
    int_pending = 1'b0;
    // R9 halt suppressed by interrupt
    wait_for(0); halt_instr = 1'b1; int_pending = 1'b1; cur_req = "R9"; cyc(3);
    halt_instr = 1'b0; int_pending = 1'b0; cyc(6);
    // R1 reset in mid cycle
    wait_for(1); rst = 1'b1; cur_req = "R1"; cyc(2);
    rst = 1'b0; cyc(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule